// File: doc/BRIEF.md
# GPIO Port Control Register File

This block holds the control registers of one general-purpose I/O port with eight pins. It sits on a simple register bus: an address, a write strobe, write data, and read data that is combinational from the address. It drives a per-pin output-enable vector and one configuration byte per pin. Pad circuits, input synchronisers, output data and interrupts belong to other blocks.

Pin direction can be written whole, or changed bit by bit through two alias addresses. Writing ones to the set alias turns the chosen pins into outputs. Writing ones to the clear alias turns them into inputs. All other pins keep their direction, so software never needs a read-modify-write. For configuration, software can first load a one-shot pin mask. The next write to any pin configuration address then lands in every pin the mask selects, as well as in the addressed pin. After that write the mask clears itself.

Top module: `gpio_cfg_regs`

## Requirements
- R1: After reset, pin_oe is 0, every pin configuration byte is 0, and the mask reads 0.
- R2: A write to offset 0x00 loads the direction register from the write data, one bit per pin. Bit n = 1 makes pin n an output (pin_oe[n] = 1) and bit n = 0 makes it an input. pin_oe shows the new value from the first clock edge after the write.
- R3: A write to offset 0x01 sets each direction bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x02 clears each direction bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A read of offset 0x00, 0x01 or 0x02 returns the current direction register.
- R6: Offset 0x08 holds the mask, where bit n selects pin n. A write loads the mask, a read returns it, and the mask keeps its value across writes to other non-configuration offsets.
- R7: The configuration byte of pin n is at offset 0x10+n and appears on pin_cfg[8n+7:8n]. A read of that offset returns the byte. With the mask at 0, a write there changes only pin n.
- R8: With a nonzero mask, a write to offset 0x10+k stores the write data in every pin whose mask bit is 1. It also stores it in pin k, even if mask bit k is 0. All other pins keep their bytes.
- R9: The clock edge that takes in any pin configuration write also clears the mask to 0, so the next configuration write reaches only its addressed pin.
- R10: Writes to unmapped offsets change no output or register, reads of them return 0, and nothing changes while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_oe | output | 8 | Output enable per pin (1 = output) |
| pin_cfg | output | 64 | Configuration bytes, pin n at bits 8n+7:8n |

## Verification
Two things happen on the same edge: a masked configuration write is spread to several pins, and the mask clears itself. The bench loads a mask and then writes one configuration address. In one case the addressed pin lies outside the mask, and in another it lies inside it. After that edge it compares the whole pin_cfg vector with a model. It then reads the mask back to confirm it is 0, and makes one more configuration write to show that this write reaches only its own pin.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    // One flag per register group; used both as an address hit and as a write strobe
    typedef struct packed {
        logic dir_wr;
        logic set_wr;
        logic clr_wr;
        logic mask_wr;
        logic cfg_wr;
    } bus_dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_cfg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int PINS     = 8,
    parameter int DIR_OFS  = 0,
    parameter int SET_OFS  = 1,
    parameter int CLR_OFS  = 2,
    parameter int MASK_OFS = 8,
    parameter int CFG_OFS  = 16,
    localparam int IDX_W   = $clog2(PINS)
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output bus_dec_t          hit,
    output bus_dec_t          wr,
    output logic [IDX_W-1:0]  cfg_idx
);

    logic [ADDR_W-1:0] cfg_off;

    always_comb begin
        cfg_off      = bus_addr - ADDR_W'(CFG_OFS);
        cfg_idx      = cfg_off[IDX_W-1:0];
        hit          = '0;
        hit.dir_wr   = (bus_addr == ADDR_W'(DIR_OFS));
        hit.set_wr   = (bus_addr == ADDR_W'(SET_OFS));
        hit.clr_wr   = (bus_addr == ADDR_W'(CLR_OFS));
        hit.mask_wr  = (bus_addr == ADDR_W'(MASK_OFS));
        hit.cfg_wr   = (bus_addr >= ADDR_W'(CFG_OFS)) && (cfg_off < ADDR_W'(PINS));
        wr           = bus_we ? hit : '0;
    end

endmodule

// File: rtl/gpio_dir_unit.sv
module gpio_dir_unit
    import gpio_cfg_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_dec_t        wr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q
);

    typedef struct packed {
        logic [PINS-1:0] dir;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr.dir_wr) st_d.dir = wdata;
        if (wr.set_wr) st_d.dir = st_q.dir | wdata;
        if (wr.clr_wr) st_d.dir = st_q.dir & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int PINS  = 8,
    parameter int CFG_W = 8,
    localparam int IDX_W = $clog2(PINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bus_dec_t              wr,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [CFG_W-1:0]      wdata,
    output logic [PINS-1:0]       mask_q,
    output logic [PINS*CFG_W-1:0] cfg_flat
);

    typedef struct packed {
        logic [PINS-1:0]            mask;
        logic [PINS-1:0][CFG_W-1:0] cfg;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr.mask_wr) st_d.mask = wdata[PINS-1:0];
        if (wr.cfg_wr) begin
            for (int i = 0; i < PINS; i++) begin
                if (st_q.mask[i] || (cfg_idx == IDX_W'(i))) st_d.cfg[i] = wdata;
            end
            st_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign cfg_flat[g*CFG_W +: CFG_W] = st_q.cfg[g];
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_cfg_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(PINS)
) (
    input  bus_dec_t               hit,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [PINS-1:0]        dir_q,
    input  logic [PINS-1:0]        mask_q,
    input  logic [PINS*DATA_W-1:0] cfg_flat,
    output logic [DATA_W-1:0]      rdata
);

    always_comb begin
        rdata = '0;
        if (hit.dir_wr || hit.set_wr || hit.clr_wr) rdata[PINS-1:0] = dir_q;
        else if (hit.mask_wr)                       rdata[PINS-1:0] = mask_q;
        else if (hit.cfg_wr)                        rdata = cfg_flat[int'(cfg_idx)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_cfg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int PINS     = 8,
    parameter int DIR_OFS  = 0,
    parameter int SET_OFS  = 1,
    parameter int CLR_OFS  = 2,
    parameter int MASK_OFS = 8,
    parameter int CFG_OFS  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [PINS-1:0]        pin_oe,
    output logic [PINS*DATA_W-1:0] pin_cfg
);

    localparam int IDX_W = $clog2(PINS);

    bus_dec_t          hit, wr;
    logic [IDX_W-1:0]  cfg_idx;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   mask_q;

    gpio_addr_dec #(
        .ADDR_W(ADDR_W), .PINS(PINS), .DIR_OFS(DIR_OFS), .SET_OFS(SET_OFS),
        .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS), .CFG_OFS(CFG_OFS)
    ) u_dec (
        .bus_addr(bus_addr), .bus_we(bus_we), .hit(hit), .wr(wr), .cfg_idx(cfg_idx)
    );

    gpio_dir_unit #(.PINS(PINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr(wr), .wdata(bus_wdata[PINS-1:0]), .dir_q(dir_q)
    );

    gpio_cfg_bank #(.PINS(PINS), .CFG_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(wr), .cfg_idx(cfg_idx), .wdata(bus_wdata),
        .mask_q(mask_q), .cfg_flat(pin_cfg)
    );

    gpio_rd_mux #(.PINS(PINS), .DATA_W(DATA_W)) u_rd (
        .hit(hit), .cfg_idx(cfg_idx), .dir_q(dir_q), .mask_q(mask_q),
        .cfg_flat(pin_cfg), .rdata(bus_rdata)
    );

    assign pin_oe = dir_q;

endmodule

// File: rtl/gpio_cfg_regs_chk.sv
module gpio_cfg_regs_chk #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int PINS     = 8,
    parameter int DIR_OFS  = 0,
    parameter int SET_OFS  = 1,
    parameter int CLR_OFS  = 2,
    parameter int MASK_OFS = 8,
    parameter int CFG_OFS  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [PINS-1:0]        pin_oe,
    input logic [PINS*DATA_W-1:0] pin_cfg,
    input logic [PINS-1:0]        mask_q
);

    logic cfg_addr;
    assign cfg_addr = (int'(bus_addr) >= CFG_OFS) && (int'(bus_addr) < CFG_OFS + PINS);

    // R2
    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == DIR_OFS) |=> pin_oe == $past(bus_wdata[PINS-1:0]));

    // R3
    a_r3_set_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == SET_OFS) |=>
            pin_oe == ($past(pin_oe) | $past(bus_wdata[PINS-1:0])));

    // R4
    a_r4_clr_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == CLR_OFS) |=>
            pin_oe == ($past(pin_oe) & ~$past(bus_wdata[PINS-1:0])));

    // R9
    a_r9_mask_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && cfg_addr) |=> mask_q == '0);

    // R10
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_oe) && $stable(pin_cfg) && $stable(mask_q)));

    // R6
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == MASK_OFS) |=> mask_q == $past(bus_wdata[PINS-1:0]));

endmodule

bind gpio_cfg_regs gpio_cfg_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS), .DIR_OFS(DIR_OFS), .SET_OFS(SET_OFS),
    .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS), .CFG_OFS(CFG_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .pin_oe(pin_oe), .pin_cfg(pin_cfg), .mask_q(mask_q)
);

// File: tb/gpio_cfg_regs_test.sv
`timescale 1ns/100ps
module gpio_cfg_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_oe;
    logic [63:0] pin_cfg;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [7:0] dir_m = '0;
    logic [7:0] mask_m = '0;
    logic [7:0] cfg_m [8];

    // scoreboard queues: kind 0 = read data, 1 = pin_oe, 2 = pin_cfg
    int          kind_q [$];
    logic [63:0] exp_q  [$];
    string       tag_q  [$];

    always #2.5 clk = ~clk;

    gpio_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_cfg(pin_cfg)
    );

    function automatic logic [63:0] cfg_flat_m();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = cfg_m[i];
        return v;
    endfunction

    function automatic logic [7:0] rd_m(input logic [5:0] a);
        if (a == 6'h00 || a == 6'h01 || a == 6'h02) return dir_m;
        if (a == 6'h08) return mask_m;
        if (a >= 6'h10 && a <= 6'h17) return cfg_m[a - 6'h10];
        return 8'h00;
    endfunction

    task automatic push(input int k, input logic [63:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 6'h00) dir_m = d;
        else if (a == 6'h01) dir_m = dir_m | d;
        else if (a == 6'h02) dir_m = dir_m & ~d;
        else if (a == 6'h08) mask_m = d;
        else if (a >= 6'h10 && a <= 6'h17) begin
            for (int i = 0; i < 8; i++)
                if (mask_m[i] || (i == int'(a - 6'h10))) cfg_m[i] = d;
            mask_m = '0;
        end
    endtask

    task automatic rd(input logic [5:0] a, input string t);
        @(negedge clk);
        bus_addr = a;
        push(0, {56'b0, rd_m(a)}, t);
        @(negedge clk);
    endtask

    task automatic chk_out(input string t);
        push(1, {56'b0, dir_m}, t);
        push(2, cfg_flat_m(), t);
        @(negedge clk);
    endtask

    // monitor: compares after each rising edge, while inputs are quiet
    always @(posedge clk) begin
        int          k;
        logic [63:0] e, got;
        string       t;
        #2;
        while (kind_q.size() > 0) begin
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = (k == 0) ? {56'b0, bus_rdata} : (k == 1) ? {56'b0, pin_oe} : pin_cfg;
            checks++;
            if (got !== e) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, got, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) cfg_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_out("R1 reset outputs");
        rd(6'h08, "R1 reset mask");
        rd(6'h13, "R1 reset cfg pin3");

        wr(6'h00, 8'hA5); chk_out("R2 dir load");
        rd(6'h00, "R5 read dir");
        wr(6'h01, 8'h0A); chk_out("R3 set alias");
        rd(6'h01, "R5 read via set alias");
        wr(6'h02, 8'h81); chk_out("R4 clear alias");
        rd(6'h02, "R5 read via clear alias");
        wr(6'h00, 8'h00); chk_out("R2 all inputs");

        wr(6'h13, 8'h5C); chk_out("R7 single pin write");
        rd(6'h13, "R7 read pin3");
        rd(6'h12, "R7 neighbour untouched");

        wr(6'h08, 8'h96); rd(6'h08, "R6 mask readback");
        wr(6'h01, 8'h40); rd(6'h08, "R6 mask kept across dir write");
        wr(6'h10, 8'h3B); chk_out("R8 broadcast, target outside mask");
        rd(6'h08, "R9 mask cleared");
        wr(6'h15, 8'h11); chk_out("R9 next write single pin");

        wr(6'h08, 8'h04);
        wr(6'h12, 8'h77); chk_out("R8 broadcast, target inside mask");
        rd(6'h17, "R8 read pin7");
        rd(6'h08, "R9 mask cleared again");

        wr(6'h05, 8'hFF); chk_out("R10 unmapped write");
        rd(6'h05, "R10 unmapped read");
        rd(6'h3F, "R10 top unmapped read");
        @(negedge clk); bus_addr = 6'h00; bus_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        chk_out("R10 strobe low hold");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule